// File: doc/BRIEF.md
# Multiplexed Address/Data Port Controller

This block is the digital control of an eight-pin port whose pins serve either as general-purpose open-drain I/O or as a push-pull multiplexed address/data bus. Each pin slice has a one-bit port latch. In port mode the lower (pull-down) transistor gate follows the inverse of the latch and the upper (pull-up) gate is held off. A latch bit of 1 therefore releases the pin to an external pull-up, and a latch bit of 0 pulls the pin low.

In bus mode the latch is disconnected from the output stage. The upper gate follows the address/data bit and the lower gate follows its inverse, so exactly one transistor conducts and the pin is actively driven.

The CPU side loads the latch with a write strobe. It reads back either the sampled pin levels or the stored latch contents through two separate read strobes. To use a pin as an input, software first writes 1 to that pin's latch bit and then reads the pin.

Top module: `adport`

## Requirements
- R1: After reset every latch bit is 1, so a latch read returns 0xFF, both gate-drive outputs are all zero, and the port is in port mode.
- R2: When `wrLatch` is high at a rising clock edge, every latch bit takes the matching bit of `busDataIn`. With `wrLatch` low, the latch keeps its value.
- R3: While `busMode` is 0, `upperDrive` is all zero whatever `adOut` carries.
- R4: While `busMode` is 0, each bit of `lowerDrive` is the inverse of its latch bit (1 = transistor on, pin pulled low).
- R5: While `busMode` is 1, `upperDrive` equals `adOut` and `lowerDrive` equals the bitwise inverse of `adOut`.
- R6: The latch contents are independent of `busMode`. Writes in bus mode still load the latch without affecting the gates. On return to port mode, `lowerDrive` again reflects the stored latch.
- R7: While `rdPin` is 1, `busDataOut` equals `pinIn` in the same cycle.
- R8: While `rdLatch` is 1 and `rdPin` is 0, `busDataOut` equals the stored latch value, not the pin level.
- R9: When `rdPin` and `rdLatch` are both 1, the pin value is returned.
- R10: When neither read strobe is active, `busDataOut` is all zero.
- R11: A latch read in the same cycle as a latch write returns the old latch value. The new value is visible from the next cycle.
- R12: A pin whose latch bit is 1 in port mode has its lower gate off, so a pin read returns the externally applied level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busDataIn | input | 8 | Internal data bus, written into the latch |
| wrLatch | input | 1 | Latch write strobe |
| rdPin | input | 1 | Read-pin strobe |
| rdLatch | input | 1 | Read-latch strobe |
| busMode | input | 1 | 1 selects address/data drive, 0 selects port mode |
| adOut | input | 8 | Address/data byte from the external-bus logic |
| pinIn | input | 8 | Sampled pin levels |
| upperDrive | output | 8 | Upper transistor gates, 1 = on |
| lowerDrive | output | 8 | Lower transistor gates, 1 = on |
| busDataOut | output | 8 | Read data returned to the internal bus |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a latch write together with a latch read. The bench raises `wrLatch` with a new byte and `rdLatch` at the same falling edge. It expects the old byte on `busDataOut` before the rising edge and the new byte after it.

The second pair is the two read strobes asserted together. The bench applies a pin pattern that differs from the latch contents, so the priority rule decides which value appears, and it expects the pin pattern.

The bench models each pin as resolved from the two gate drives, a pull-up and an optional external driver. This way the port-mode, bus-mode and input-mode sequences are judged at the pins.

// File: rtl/adport_pkg.sv
package adport_pkg;
  typedef struct packed {
    logic load;
    logic takePin;
    logic takeLatch;
    logic busSel;
  } portCtl_t;
endpackage

// File: rtl/adport_ctrl.sv
module adport_ctrl
  import adport_pkg::*;
(
  input  logic     wrLatch,
  input  logic     rdPin,
  input  logic     rdLatch,
  input  logic     busMode,
  output portCtl_t ctl
);
  // Read-pin wins over read-latch (R9).
  always_comb begin
    ctl.load      = wrLatch;
    ctl.takePin   = rdPin;
    ctl.takeLatch = rdLatch & ~rdPin;
    ctl.busSel    = busMode;
  end
endmodule

// File: rtl/adport_slice.sv
module adport_slice
  import adport_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  portCtl_t ctl,
  input  logic     dIn,
  input  logic     adBit,
  output logic     upperGate,
  output logic     lowerGate,
  output logic     latchQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        latchQ <= 1'b1;
    else if (ctl.load) latchQ <= dIn;
  end

  always_comb begin
    upperGate = ctl.busSel & adBit;
    lowerGate = ctl.busSel ? ~adBit : ~latchQ;
  end

  a_r2_latch_load: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> latchQ == $past(dIn));
  a_r2_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(latchQ));
  a_r5_one_conducts: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busSel |-> (upperGate != lowerGate));
endmodule

// File: rtl/adport_dp.sv
module adport_dp
  import adport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  portCtl_t         ctl,
  input  logic [WIDTH-1:0] dIn,
  input  logic [WIDTH-1:0] adVec,
  input  logic [WIDTH-1:0] pinVec,
  output logic [WIDTH-1:0] upperVec,
  output logic [WIDTH-1:0] lowerVec,
  output logic [WIDTH-1:0] readVec
);
  logic [WIDTH-1:0] latchVec;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    adport_slice u_slice (
      .clk       (clk),
      .rstN      (rstN),
      .ctl       (ctl),
      .dIn       (dIn[i]),
      .adBit     (adVec[i]),
      .upperGate (upperVec[i]),
      .lowerGate (lowerVec[i]),
      .latchQ    (latchVec[i])
    );
  end

  always_comb begin
    if (ctl.takePin)        readVec = pinVec;
    else if (ctl.takeLatch) readVec = latchVec;
    else                    readVec = '0;
  end

  a_r3_upper_off: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.busSel |-> upperVec == '0);
  a_r9_pin_first: assert property (@(posedge clk) disable iff (!rstN)
    ctl.takePin |-> readVec == pinVec);
  a_r11_old_value: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && ctl.takeLatch) |-> readVec == ~lowerVec || ctl.busSel);
endmodule

// File: rtl/adport.sv
module adport
  import adport_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] busDataIn,
  input  logic             wrLatch,
  input  logic             rdPin,
  input  logic             rdLatch,
  input  logic             busMode,
  input  logic [WIDTH-1:0] adOut,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] upperDrive,
  output logic [WIDTH-1:0] lowerDrive,
  output logic [WIDTH-1:0] busDataOut
);
  portCtl_t ctl;

  adport_ctrl u_ctrl (
    .wrLatch (wrLatch),
    .rdPin   (rdPin),
    .rdLatch (rdLatch),
    .busMode (busMode),
    .ctl     (ctl)
  );

  adport_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .dIn      (busDataIn),
    .adVec    (adOut),
    .pinVec   (pinIn),
    .upperVec (upperDrive),
    .lowerVec (lowerDrive),
    .readVec  (busDataOut)
  );

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    (!rdPin && !rdLatch) |-> busDataOut == '0);
  a_r5_bus_follows: assert property (@(posedge clk) disable iff (!rstN)
    busMode |-> (upperDrive == adOut && lowerDrive == ~adOut));
endmodule

// File: tb/adport_tb_top.sv
module adport_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busDataIn = '0;
  logic       wrLatch = 1'b0, rdPin = 1'b0, rdLatch = 1'b0, busMode = 1'b0;
  logic [7:0] adOut = '0;
  logic [7:0] pinIn;
  logic [7:0] upperDrive, lowerDrive, busDataOut;
  logic [7:0] extEn = '0, extVal = '0;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  // Pin resolution: lower on -> 0, upper on -> 1, else external driver, else pull-up.
  always_comb
    for (int i = 0; i < 8; i++)
      pinIn[i] = lowerDrive[i] ? 1'b0 : upperDrive[i] ? 1'b1 : extEn[i] ? extVal[i] : 1'b1;

  adport dut_i (
    .clk(clk), .rstN(rstN), .busDataIn(busDataIn), .wrLatch(wrLatch),
    .rdPin(rdPin), .rdLatch(rdLatch), .busMode(busMode), .adOut(adOut),
    .pinIn(pinIn), .upperDrive(upperDrive), .lowerDrive(lowerDrive),
    .busDataOut(busDataOut)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic readLatch(string req, logic [7:0] exp);
    @(negedge clk); rdLatch = 1; rdPin = 0; #2;
    check(req, busDataOut, exp);
    rdLatch = 0;
  endtask

  task automatic readPin(string req, logic [7:0] exp);
    @(negedge clk); rdPin = 1; rdLatch = 0; #2;
    check(req, busDataOut, exp);
    rdPin = 0;
  endtask

  task automatic writeLatch(logic [7:0] v);
    @(negedge clk); busDataIn = v; wrLatch = 1;
    @(negedge clk); wrLatch = 0;
  endtask

  task automatic t_reset;
    #1; check("R1 lower", lowerDrive, 8'h00);
    check("R1 upper", upperDrive, 8'h00);
    readLatch("R1 latch", 8'hFF);
  endtask

  task automatic t_port_out;
    writeLatch(8'hA5);
    adOut = 8'hFF; #1;
    check("R4 lower", lowerDrive, 8'h5A);
    check("R3 upper", upperDrive, 8'h00);
    readLatch("R2 latch", 8'hA5);
    readPin("R7 pin", 8'hA5);
    @(negedge clk); #2;
    check("R10 idle", busDataOut, 8'h00);
  endtask

  task automatic t_bus_mode;
    @(negedge clk); busMode = 1; adOut = 8'h3C; #2;
    check("R5 upper", upperDrive, 8'h3C);
    check("R5 lower", lowerDrive, 8'hC3);
    readPin("R5 pin", 8'h3C);
    @(negedge clk); adOut = 8'hC3; #2;
    check("R5 upper2", upperDrive, 8'hC3);
    readLatch("R6 kept", 8'hA5);
    writeLatch(8'h0F);
    #1; check("R6 gates", lowerDrive, 8'h3C);
    @(negedge clk); busMode = 0; #2;
    check("R6 back lower", lowerDrive, 8'hF0);
    check("R3 back upper", upperDrive, 8'h00);
  endtask

  task automatic t_input;
    writeLatch(8'hFF);
    extEn = 8'hFF; extVal = 8'h69; #1;
    check("R12 lower off", lowerDrive, 8'h00);
    readPin("R12 pin", 8'h69);
    readLatch("R8 latch not pin", 8'hFF);
    @(negedge clk); rdPin = 1; rdLatch = 1; #2;
    check("R9 priority", busDataOut, 8'h69);
    rdPin = 0; rdLatch = 0;
    extEn = 8'h00;
  endtask

  task automatic t_same_cycle;
    @(negedge clk); busDataIn = 8'h12; wrLatch = 1; rdLatch = 1; #2;
    check("R11 old", busDataOut, 8'hFF);
    @(posedge clk); #1;
    check("R11 new", busDataOut, 8'h12);
    @(negedge clk); wrLatch = 0; busDataIn = 8'h77; #2;
    check("R2 hold", busDataOut, 8'h12);
    @(posedge clk); #1;
    check("R2 hold2", busDataOut, 8'h12);
    rdLatch = 0;
  endtask

  initial begin
    fork
      begin
        #12 rstN = 1;
        t_reset(); t_port_out(); t_bus_mode(); t_input(); t_same_cycle();
      end
      begin
        #100000;
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule